// File: doc/BRIEF.md
# Peripheral Clock Gating and Sleep Controller

This block decides, for every peripheral behind it, whether that peripheral's clock runs. Software sets a per-peripheral sleep-enable bit through a small 32-bit register bus. Each peripheral drives a live clock-request line. A clock is stopped only when both agree: sleep is enabled and the peripheral has no request pending. With the default parameters there are five banks of 32 peripherals, 160 in all. Only some bits of each bank are populated, and a parameter mask marks which ones.

The block also sequences whole-system sleep. Software arms sleep in a control register, choosing light or heavy mode. When the processor then raises its sleep signal, the controller waits until no peripheral requests a clock. Unless the control register waives the check, it also waits for the PLL to report lock. It then enters the selected mode. While asleep, every peripheral without a request is gated. A wake event, or the processor dropping its sleep signal, restores the run-time gating in the same cycle and returns the controller to run on the next edge.

Top module: `pcg_ctrl`

## Requirements
- R1: After reset, all sleep-enable bits and all control bits are 0, `sleep_state` is 0 (run), and every `clk_en` bit equals 1.
- R2: The sleep-enable register for bank n is at byte address 0x30+4n and reads back what was written. Bits outside the populated mask read 0 and ignore writes. The default masks are 0x00000003 for bank 0, all ones for banks 1 to 3, and 0x0001FFFF for bank 4. Bank n, bit k controls peripheral 32n+k.
- R3: The clock-request view for bank n is at 0x50+4n. It returns the live `clk_req` bits of that bank, and writes to it change nothing.
- R4: Outside light and heavy sleep, `clk_en[i]` is 0 exactly when sleep-enable bit i is 1 and `clk_req[i]` is 0. A requesting peripheral always keeps its clock.
- R5: The control register at 0x00 keeps only bits 0, 3 and 8 of a write and reads 0 elsewhere. Bit 0 selects heavy (1) or light (0) sleep, bit 3 arms sleep, and bit 8 waives the PLL-lock condition.
- R6: The status register at 0x0C returns `pll_lock` in bit 8 and 0 in every other bit. Any other unmapped address reads 0.
- R7: In run (`sleep_state` 0), the block moves to wait (1) on the next edge only if `cpu_sleep` is 1, control bit 3 is 1 and `wake` is 0. Otherwise it stays in run.
- R8: In wait, with `cpu_sleep` 1 and `wake` 0, the block enters light (2) or heavy (3) on the next edge, per control bit 0, once all `clk_req` bits are 0 and entry is permitted. While any request is high it keeps waiting, without error or abort.
- R9: In light or heavy sleep, with `cpu_sleep` 1 and `wake` 0, `clk_en` equals `clk_req` bit for bit, regardless of sleep-enable.
- R10: In wait, light or heavy, `wake` 1 or `cpu_sleep` 0 makes `clk_en` follow R4 in that same cycle and sets `sleep_state` to 0 on the next edge.
- R11: With control bit 8 at 0 and `pll_lock` 0, the block never leaves wait for light or heavy. With bit 8 at 1, entry does not depend on `pll_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clk_req | input | 160 | Live clock request from each peripheral |
| pll_lock | input | 1 | PLL lock indication |
| cpu_sleep | input | 1 | Processor sleep signal |
| wake | input | 1 | Wake event |
| clk_en | output | 160 | Clock enable to each peripheral |
| sleep_state | output | 2 | 0 run, 1 wait, 2 light, 3 heavy |

## Verification
The assertions watch several rules on every cycle:
- No requesting peripheral ever loses its clock.
- The asleep outputs mirror the requests exactly.
- Wait holds while any request is high.
- Entry stays blocked without lock when the waiver is clear.
- A wake or a dropped sleep signal always leads back to run.
- Unarmed sleep never leaves run.
- Control writes are masked.

Other behaviour only the bench's scenarios can show. These are the address decoding of each bank, the masking of unpopulated bits, that the clock-request view ignores writes, and the choice between light and heavy. The bench compares every cycle against its own model to show these.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LIGHT = 2'd2,
    ST_HEAVY = 2'd3
  } slp_state_e;

  localparam logic [7:0] A_CTRL        = 8'h00;
  localparam logic [7:0] A_OSC         = 8'h0C;
  localparam logic [7:0] A_SLPEN_BASE  = 8'h30;
  localparam logic [7:0] A_CLKREQ_BASE = 8'h50;

  localparam int CTRL_HEAVY_BIT  = 0;
  localparam int CTRL_ARM_BIT    = 3;
  localparam int CTRL_NOLOCK_BIT = 8;
  localparam int OSC_LOCK_BIT    = 8;

  // Address of register bank idx within a strided group
  function automatic logic bank_hit(input logic [7:0] addr,
                                    input logic [7:0] base,
                                    input int idx);
    return addr == (base + 8'(idx * 4));
  endfunction

  // Control word as seen on the bus
  function automatic logic [BUS_W-1:0] ctrl_word(input logic heavy,
                                                 input logic arm,
                                                 input logic nolock);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CTRL_HEAVY_BIT]  = heavy;
    w[CTRL_ARM_BIT]    = arm;
    w[CTRL_NOLOCK_BIT] = nolock;
    return w;
  endfunction

  // Clock enables of one bank: a request always wins; otherwise the clock
  // stops if sleep-enabled or if the system is asleep.
  function automatic logic [BUS_W-1:0] gate_bank(input logic [BUS_W-1:0] slp,
                                                 input logic [BUS_W-1:0] req,
                                                 input logic asleep);
    return req | (~slp & {BUS_W{~asleep}});
  endfunction

  function automatic logic entry_ok(input logic lock, input logic nolock);
    return lock | nolock;
  endfunction

endpackage

// File: rtl/pcg_regs.sv
module pcg_regs
  import pcg_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter logic [NUM_BANKS*BUS_W-1:0] IMPL = '1,
  localparam int NPER = NUM_BANKS * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic [NPER-1:0]  clk_req,
  input  logic             pll_lock,
  output logic [NPER-1:0]  slp_en,
  output logic             heavy_sel,
  output logic             arm,
  output logic             nolock
);

  logic [BUS_W-1:0] slp_q [NUM_BANKS];
  logic             ctrl_wr;

  assign ctrl_wr = we && (addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heavy_sel <= 1'b0;
      arm       <= 1'b0;
      nolock    <= 1'b0;
    end else if (ctrl_wr) begin
      heavy_sel <= wdata[CTRL_HEAVY_BIT];
      arm       <= wdata[CTRL_ARM_BIT];
      nolock    <= wdata[CTRL_NOLOCK_BIT];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BUS_W-1:0] MASK = IMPL[b*BUS_W +: BUS_W];
    logic bank_wr;
    assign bank_wr = we && bank_hit(addr, A_SLPEN_BASE, b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slp_q[b] <= '0;
      else if (bank_wr) slp_q[b] <= wdata & MASK;
    end
    assign slp_en[b*BUS_W +: BUS_W] = slp_q[b];
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata = ctrl_word(heavy_sel, arm, nolock);
    if (addr == A_OSC)  rdata[OSC_LOCK_BIT] = pll_lock;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit(addr, A_SLPEN_BASE, b))  rdata = slp_q[b];
      if (bank_hit(addr, A_CLKREQ_BASE, b)) rdata = clk_req[b*BUS_W +: BUS_W];
    end
  end

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> {nolock, arm, heavy_sel} ==
                {$past(wdata[CTRL_NOLOCK_BIT]), $past(wdata[CTRL_ARM_BIT]),
                 $past(wdata[CTRL_HEAVY_BIT])}); // R5
  AST_SLP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(slp_en)); // R2

endmodule

// File: rtl/pcg_gate.sv
module pcg_gate
  import pcg_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  localparam int NPER = NUM_BANKS * BUS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPER-1:0] slp_en,
  input  logic [NPER-1:0] clk_req,
  input  logic            asleep,
  output logic [NPER-1:0] clk_en
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign clk_en[b*BUS_W +: BUS_W] = gate_bank(slp_en[b*BUS_W +: BUS_W],
                                                clk_req[b*BUS_W +: BUS_W],
                                                asleep);
  end

  AST_REQ_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_req & ~clk_en) == '0); // R4

endmodule

// File: rtl/pcg_sleep_fsm.sv
module pcg_sleep_fsm
  import pcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_sleep,
  input  logic       wake,
  input  logic       arm,
  input  logic       heavy_sel,
  input  logic       nolock,
  input  logic       pll_lock,
  input  logic       all_idle,
  output slp_state_e state,
  output logic       asleep
);

  slp_state_e st_q, st_d;
  logic       leave;
  logic       sleeping;

  assign leave    = wake || !cpu_sleep;
  assign sleeping = (st_q == ST_LIGHT) || (st_q == ST_HEAVY);
  assign asleep   = sleeping && !leave;
  assign state    = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (cpu_sleep && arm && !wake) st_d = ST_WAIT;
      ST_WAIT: begin
        if (leave) st_d = ST_RUN;
        else if (all_idle && entry_ok(pll_lock, nolock))
          st_d = heavy_sel ? ST_HEAVY : ST_LIGHT;
      end
      default: if (leave) st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  AST_UNARMED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !arm) |=> st_q == ST_RUN); // R7
  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !all_idle && !leave) |=> st_q == ST_WAIT); // R8
  AST_LOCK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !pll_lock && !nolock) |=> !sleeping); // R11
  AST_EXIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN && leave) |=> st_q == ST_RUN); // R10

endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter logic [NUM_BANKS*32-1:0] IMPL =
    {32'h0001_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0003},
  localparam int NPER = NUM_BANKS * 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPER-1:0] clk_req,
  input  logic            pll_lock,
  input  logic            cpu_sleep,
  input  logic            wake,
  output logic [NPER-1:0] clk_en,
  output logic [1:0]      sleep_state
);

  logic [NPER-1:0] slp_en;
  logic            heavy_sel, arm, nolock;
  logic            all_idle, asleep;
  slp_state_e      st;

  assign all_idle    = ~|clk_req;
  assign sleep_state = st;

  pcg_regs #(.NUM_BANKS(NUM_BANKS), .IMPL(IMPL)) u_regs (
    .clk, .rst_n, .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .clk_req, .pll_lock, .slp_en,
    .heavy_sel, .arm, .nolock
  );

  pcg_sleep_fsm u_fsm (
    .clk, .rst_n, .cpu_sleep, .wake, .arm, .heavy_sel, .nolock,
    .pll_lock, .all_idle, .state(st), .asleep
  );

  pcg_gate #(.NUM_BANKS(NUM_BANKS)) u_gate (
    .clk, .rst_n, .slp_en, .clk_req, .asleep, .clk_en
  );

  AST_SLEEP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_LIGHT || st == ST_HEAVY) && cpu_sleep && !wake)
      |-> clk_en == clk_req); // R9

endmodule

// File: tb/pcg_ctrl_tb.sv
module pcg_ctrl_tb;

  localparam int NB = 5;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = 8'h00;
  logic [31:0]   bus_wdata = 32'h0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] clk_req = '0;
  logic          pll_lock = 1'b0;
  logic          cpu_sleep = 1'b0;
  logic          wake = 1'b0;
  logic [NP-1:0] clk_en;
  logic [1:0]    sleep_state;

  always #2 clk = ~clk;

  pcg_ctrl u_dut (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .clk_req, .pll_lock, .cpu_sleep, .wake, .clk_en, .sleep_state
  );

  // Reference model
  logic [31:0] impl [NB] = '{32'h0000_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                             32'hFFFF_FFFF, 32'h0001_FFFF};
  logic [31:0] m_slp [NB] = '{default: 32'h0};
  logic m_heavy = 0, m_arm = 0, m_nolock = 0;
  int   m_st = 0;

  int    errors = 0, checks = 0;
  string tag = "R1";
  bit    running = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_heavy = 0; m_arm = 0; m_nolock = 0;
      for (int b = 0; b < NB; b++) m_slp[b] = 0;
    end else begin
      if (m_st == 0) begin
        if (cpu_sleep && m_arm && !wake) m_st = 1;
      end else if (m_st == 1) begin
        if (!cpu_sleep || wake) m_st = 0;
        else if (clk_req == 0 && (pll_lock || m_nolock)) m_st = m_heavy ? 3 : 2;
      end else if (!cpu_sleep || wake) m_st = 0;
      if (bus_we) begin
        if (bus_addr == 8'h00) begin
          m_heavy = bus_wdata[0]; m_arm = bus_wdata[3]; m_nolock = bus_wdata[8];
        end
        for (int b = 0; b < NB; b++)
          if (bus_addr == 8'h30 + 8'(4*b)) m_slp[b] = bus_wdata & impl[b];
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = 0;
    if (bus_addr == 8'h00) r = {23'h0, m_nolock, 4'h0, m_arm, 2'h0, m_heavy};
    if (bus_addr == 8'h0C) r = {23'h0, pll_lock, 8'h0};
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == 8'h30 + 8'(4*b)) r = m_slp[b];
      if (bus_addr == 8'h50 + 8'(4*b)) r = clk_req[32*b +: 32];
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_en();
    logic [NP-1:0] e;
    bit asleep = (m_st >= 2) && cpu_sleep && !wake;
    for (int i = 0; i < NP; i++) begin
      if (clk_req[i]) e[i] = 1'b1;
      else if (asleep) e[i] = 1'b0;
      else e[i] = !m_slp[i/32][i%32];
    end
    return e;
  endfunction

  task automatic check(string what, logic [NP-1:0] got, logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      #1;
      check("sleep_state", NP'(sleep_state), NP'(m_st));
      check("clk_en", clk_en, exp_en());
      check("bus_rdata", NP'(bus_rdata), NP'(exp_rdata()));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); bus_addr = a;
    cyc(1);
  endtask

  initial begin
    @(posedge clk); running = 1;
    tag = "R1"; cyc(3); rst_n = 1; cyc(2);

    tag = "R5"; wr(8'h00, 32'hFFFF_FFFF); rd(8'h00); wr(8'h00, 32'h0); rd(8'h00);
    tag = "R6"; rd(8'h0C); pll_lock = 1; cyc(1); rd(8'h24); pll_lock = 0; rd(8'h0C);

    tag = "R2";
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40);
    wr(8'h38, 32'hA5A5_5A5A); rd(8'h38); rd(8'h34);

    tag = "R3";
    clk_req = {32'h0000_00F0, 32'h1, 32'h8000_0001, 32'h0, 32'h2};
    for (int b = 0; b < NB; b++) rd(8'h50 + 8'(4*b));
    wr(8'h54, 32'hFFFF_FFFF); rd(8'h54); rd(8'h34);

    tag = "R4";
    clk_req = '0; cyc(1);
    clk_req[64 +: 32] = 32'h0000_FFFF; cyc(2);
    clk_req[1] = 1'b1; cyc(2);
    clk_req = '0; wr(8'h30, 32'h1); cyc(2);

    tag = "R7";
    cpu_sleep = 1; cyc(3); cpu_sleep = 0; cyc(1);

    tag = "R8";
    wr(8'h00, 32'h0000_0008); rd(8'h00);
    pll_lock = 1; clk_req[70] = 1'b1;
    cpu_sleep = 1; cyc(3);
    clk_req[70] = 1'b0; clk_req[130] = 1'b1; cyc(2);
    clk_req = '0; cyc(2);

    tag = "R9";
    clk_req[5] = 1'b1; cyc(2); clk_req = '0; cyc(1);

    tag = "R10";
    wake = 1; cyc(1); wake = 0; cyc(2);
    cpu_sleep = 0; cyc(2);

    tag = "R11";
    pll_lock = 0; cpu_sleep = 1; cyc(4);
    pll_lock = 1; cyc(2);
    cpu_sleep = 0; cyc(2);
    wr(8'h00, 32'h0000_0109); pll_lock = 0;
    cpu_sleep = 1; cyc(3);
    tag = "R9"; cyc(1);
    tag = "R10"; cpu_sleep = 0; cyc(2);

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule